// File: doc/BRIEF.md
# Fault Diagnostic Output Override

This block sits between a sensor conditioner's signal path and its outputs. It watches five fault indications: a checksum failure of the configuration memory, a RAM parity error, a parity error in the configuration registers, a bridge-connection fault reported by two window comparators, and a common-mode-out-of-limits flag. The common-mode flag comes with a 13-bit measured value.

A fault input must stay high for a qualification time before it is accepted. The default is about 1 ms at the system clock. Once accepted, the fault is latched. While any fault is latched, the block replaces the serial-interface output word with a fixed error code for that fault class. It also forces the DAC code to its lowest or highest value, which places the analog output in the diagnostic region below 2.5 % or above 97.5 % of the supply.

Each fault class has its own code and its own rail. Enable bits gate every check except the checksum check, which is always active. A latched fault stays until reset or until a new configuration load.

Top module: `fault_diag`

## Requirements
- R1: After reset, and while no fault is latched, `sif_word_o` equals `sif_word_i`, `dac_code_o` equals `dac_code_i`, `diag_act_o` is 0 and `flt_stat_o` is 0.
- R2: A fault is latched only when its gated input is sampled high on QUAL_CYC consecutive rising clock edges; it latches on the QUAL_CYC-th edge. A shorter pulse leaves every output unchanged.
- R3: A latched checksum fault (`crc_err_i`) gives `sif_word_o` = 0xCAAA and `dac_code_o` = all zeros. This check ignores `chk_en_i`.
- R4: A latched RAM parity fault gives 0xCF0F and all-zero DAC code. It is checked only while `chk_en_i[0]` is 1.
- R5: A latched register parity fault gives 0xCE38 and all-zero DAC code. It is checked only while `chk_en_i[1]` is 1.
- R6: A bridge-connection fault is raised when either `brg_lo_i` or `brg_hi_i` is high. It gives 0xCFCF and all-ones DAC code, with `diag_hi_o` = 1. It is checked only while `chk_en_i[2]` is 1.
- R7: A latched common-mode fault gives 0xE000 plus the `cm_val_i` sampled on the qualifying edge, and all-ones DAC code. The reported value does not follow later changes of `cm_val_i`. It is checked only while `chk_en_i[3]` is 1.
- R8: With several faults latched, the code and rail come from the first latched class in this order: checksum, RAM parity, register parity, connection, common mode.
- R9: Latched faults stay after their inputs fall. A cycle with `cfg_reload_i` high clears all of them and all qualification progress, and this overrides a qualifying input in the same cycle. `rst_ni` low also clears them.
- R10: `flt_stat_o` holds one sticky bit per latched class: bit 0 checksum, bit 1 RAM parity, bit 2 register parity, bit 3 connection, bit 4 common mode.
- R11: A fault input whose enable bit is 0 never latches, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_reload_i | input | 1 | New configuration load; clears latched faults |
| chk_en_i | input | 4 | Check enables: [0] RAM parity, [1] register parity, [2] connection, [3] common mode |
| crc_err_i | input | 1 | Configuration-memory checksum failure |
| ram_par_err_i | input | 1 | RAM parity error |
| reg_par_err_i | input | 1 | Configuration-register parity error |
| brg_lo_i | input | 1 | Bridge input below window |
| brg_hi_i | input | 1 | Bridge input above window |
| cm_oor_i | input | 1 | Common mode out of limits |
| cm_val_i | input | 13 | Measured common-mode value |
| sif_word_i | input | 16 | Normal serial output word |
| dac_code_i | input | DW | Normal DAC code |
| sif_word_o | output | 16 | Serial output word after override |
| dac_code_o | output | DW | DAC code after override |
| diag_act_o | output | 1 | Diagnostic override active |
| diag_hi_o | output | 1 | Active override uses the high rail |
| flt_stat_o | output | 5 | Sticky latched-fault vector |

## Verification
Two situations are hard to reach from the ports. The first is several classes latched at the same time, with a lower-priority fault arriving while a higher one already owns the outputs. The second is a qualifying input that lands on the same edge as a configuration load.

The stimulus holds one fault latched and then qualifies a second one behind it. It also raises all five inputs together, and it releases a fault one cycle before the qualification count completes to show that the pulse is ignored. It times a reload to the exact qualifying edge. It then changes `cm_val_i` after the common-mode fault has latched, to show that the reported value stays frozen.

// File: rtl/fault_diag_pkg.sv
package fault_diag_pkg;
  localparam int NFLT = 5;
  localparam int CMW  = 13;

  typedef enum int {
    FLT_CRC  = 0,
    FLT_RAM  = 1,
    FLT_REG  = 2,
    FLT_CONN = 3,
    FLT_CM   = 4
  } flt_e;

  function automatic logic [15:0] err_code(input int idx, input logic [CMW-1:0] cm);
    case (idx)
      FLT_CRC:  err_code = 16'hCAAA;
      FLT_RAM:  err_code = 16'hCF0F;
      FLT_REG:  err_code = 16'hCE38;
      FLT_CONN: err_code = 16'hCFCF;
      default:  err_code = 16'hE000 + {3'b000, cm};
    endcase
  endfunction

  function automatic logic rail_hi(input int idx);
    rail_hi = (idx == FLT_CONN) || (idx == FLT_CM);
  endfunction
endpackage

// File: rtl/fault_qual.sv
module fault_qual #(
  parameter int QUAL_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic set_o,
  output logic flag_o
);
  localparam int CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);

  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit   = (cnt_q == CW'(QUAL_CYC - 1));
  assign set_o = raw_i && !flag_o && hit && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (!flag_o) begin
      if (!raw_i) begin
        cnt_q <= '0;
      end else if (hit) begin
        flag_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fault_prio.sv
module fault_prio
  import fault_diag_pkg::*;
(
  input  logic [NFLT-1:0] stat_i,
  input  logic [CMW-1:0]  cm_i,
  output logic            act_o,
  output logic            hi_o,
  output logic [15:0]     code_o
);
  always_comb begin
    act_o  = 1'b0;
    hi_o   = 1'b0;
    code_o = '0;
    // lowest index wins: scan from the bottom of the order upward
    for (int i = NFLT - 1; i >= 0; i--) begin
      if (stat_i[i]) begin
        act_o  = 1'b1;
        hi_o   = rail_hi(i);
        code_o = err_code(i, cm_i);
      end
    end
  end
endmodule

// File: rtl/fault_diag.sv
module fault_diag
  import fault_diag_pkg::*;
#(
  parameter int DW       = 12,
  parameter int QUAL_CYC = 50000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_reload_i,
  input  logic [3:0]      chk_en_i,
  input  logic            crc_err_i,
  input  logic            ram_par_err_i,
  input  logic            reg_par_err_i,
  input  logic            brg_lo_i,
  input  logic            brg_hi_i,
  input  logic            cm_oor_i,
  input  logic [12:0]     cm_val_i,
  input  logic [15:0]     sif_word_i,
  input  logic [DW-1:0]   dac_code_i,
  output logic [15:0]     sif_word_o,
  output logic [DW-1:0]   dac_code_o,
  output logic            diag_act_o,
  output logic            diag_hi_o,
  output logic [4:0]      flt_stat_o
);
  logic [NFLT-1:0] raw, set;
  logic [CMW-1:0]  cm_q;
  logic [15:0]     code;

  assign raw[FLT_CRC]  = crc_err_i;
  assign raw[FLT_RAM]  = ram_par_err_i & chk_en_i[0];
  assign raw[FLT_REG]  = reg_par_err_i & chk_en_i[1];
  assign raw[FLT_CONN] = (brg_lo_i | brg_hi_i) & chk_en_i[2];
  assign raw[FLT_CM]   = cm_oor_i & chk_en_i[3];

  for (genvar g = 0; g < NFLT; g++) begin : g_qual
    fault_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cfg_reload_i),
      .raw_i  (raw[g]),
      .set_o  (set[g]),
      .flag_o (flt_stat_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cm_q <= '0;
    else if (set[FLT_CM])  cm_q <= cm_val_i;
  end

  fault_prio u_prio (
    .stat_i (flt_stat_o),
    .cm_i   (cm_q),
    .act_o  (diag_act_o),
    .hi_o   (diag_hi_o),
    .code_o (code)
  );

  assign sif_word_o = diag_act_o ? code : sif_word_i;
  assign dac_code_o = diag_act_o ? {DW{diag_hi_o}} : dac_code_i;
endmodule

// File: rtl/fault_diag_chk.sv
module fault_diag_chk #(
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_reload_i,
  input logic          crc_err_i,
  input logic          ram_par_err_i,
  input logic [15:0]   sif_word_i,
  input logic [DW-1:0] dac_code_i,
  input logic [15:0]   sif_word_o,
  input logic [DW-1:0] dac_code_o,
  input logic          diag_act_o,
  input logic          diag_hi_o,
  input logic [4:0]    flt_stat_o
);
  // R1
  pass_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_stat_o == 5'd0) |-> (sif_word_o == sif_word_i && dac_code_o == dac_code_i && !diag_act_o));

  // R2
  crc_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flt_stat_o[0]) |-> $past(crc_err_i));

  // R3
  crc_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_stat_o[0] |-> (sif_word_o == 16'hCAAA && dac_code_o == '0));

  // R8
  ram_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_stat_o[1:0] == 2'b10) |-> (sif_word_o == 16'hCF0F && dac_code_o == '0));

  // R6
  hi_rail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_act_o && diag_hi_o) |-> (dac_code_o == '1 && flt_stat_o[2:0] == 3'd0));

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_reload_i |=> ((flt_stat_o & $past(flt_stat_o)) == $past(flt_stat_o)));

  // R9
  reload_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reload_i |=> (flt_stat_o == 5'd0));
endmodule

bind fault_diag fault_diag_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_reload_i  (cfg_reload_i),
  .crc_err_i     (crc_err_i),
  .ram_par_err_i (ram_par_err_i),
  .sif_word_i    (sif_word_i),
  .dac_code_i    (dac_code_i),
  .sif_word_o    (sif_word_o),
  .dac_code_o    (dac_code_o),
  .diag_act_o    (diag_act_o),
  .diag_hi_o     (diag_hi_o),
  .flt_stat_o    (flt_stat_o)
);

// File: tb/fault_diag_tb_top.sv
module fault_diag_tb_top;
  localparam int DW = 12;
  localparam int Q  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic [3:0] en = 4'h0;
  logic crc = 1'b0, ram = 1'b0, regp = 1'b0, blo = 1'b0, bhi = 1'b0, cm = 1'b0;
  logic [12:0] cmv = '0;
  logic [15:0] sif_i = 16'h1234;
  logic [DW-1:0] dac_i = 12'h5A5;
  logic [15:0] sif_o;
  logic [DW-1:0] dac_o;
  logic act, hi;
  logic [4:0] stat;

  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  fault_diag #(.DW(DW), .QUAL_CYC(Q)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_reload_i(reload), .chk_en_i(en),
    .crc_err_i(crc), .ram_par_err_i(ram), .reg_par_err_i(regp),
    .brg_lo_i(blo), .brg_hi_i(bhi), .cm_oor_i(cm), .cm_val_i(cmv),
    .sif_word_i(sif_i), .dac_code_i(dac_i), .sif_word_o(sif_o),
    .dac_code_o(dac_o), .diag_act_o(act), .diag_hi_o(hi), .flt_stat_o(stat)
  );

  // behavioural reference
  int m_cnt[5];
  bit m_lat[5];
  logic [12:0] m_cm;

  function automatic bit m_raw(int i);
    case (i)
      0: return crc;
      1: return ram & en[0];
      2: return regp & en[1];
      3: return (blo | bhi) & en[2];
      default: return cm & en[3];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || reload) begin
      foreach (m_lat[i]) begin m_lat[i] = 0; m_cnt[i] = 0; end
      if (!rst_n) m_cm = '0;
    end else begin
      for (int i = 0; i < 5; i++) begin
        if (m_lat[i]) continue;
        if (!m_raw(i)) m_cnt[i] = 0;
        else begin
          m_cnt[i]++;
          if (m_cnt[i] == Q) begin
            m_lat[i] = 1;
            if (i == 4) m_cm = cmv;
          end
        end
      end
    end
  end

  function automatic int m_top();
    for (int i = 0; i < 5; i++) if (m_lat[i]) return i;
    return -1;
  endfunction

  function automatic logic [15:0] m_code(int i);
    case (i)
      0: return 16'hCAAA;
      1: return 16'hCF0F;
      2: return 16'hCE38;
      3: return 16'hCFCF;
      default: return 16'hE000 + {3'b0, m_cm};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk);
    #5;
    begin
      int t;
      logic [4:0] es;
      t = m_top();
      es = {m_lat[4], m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
      chk("R10 stat", stat, es);
      if (t < 0) begin
        chk("R1 sif", sif_o, sif_i);
        chk("R1 dac", dac_o, dac_i);
        chk("R1 act", act, 0);
      end else begin
        chk("R8 code", sif_o, m_code(t));
        chk("R8 dac", dac_o, (t >= 3) ? 12'hFFF : 12'h000);
        chk("R8 hi", hi, t >= 3);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  task automatic do_reload();
    @(negedge clk); reload = 1;
    @(negedge clk); reload = 0;
  endtask

  initial begin : wdog
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    settle();
    chk("R1 reset stat", stat, 0);
    chk("R1 reset sif", sif_o, 16'h1234);
    @(negedge clk); sif_i = 16'hBEEF; dac_i = 12'h0F3;
    settle();
    chk("R1 pass sif", sif_o, 16'hBEEF);
    chk("R1 pass dac", dac_o, 12'h0F3);

    // R2: Q-1 cycles then drop
    @(negedge clk); crc = 1;
    cyc(Q - 1); crc = 0;
    settle();
    chk("R2 short pulse", act, 0);

    // R3: crc with all enables off, exact latch edge
    @(negedge clk); crc = 1;
    repeat (Q - 1) @(posedge clk);
    #5 chk("R2 not yet", act, 0);
    settle();
    chk("R2 latched", act, 1);
    chk("R3 code", sif_o, 16'hCAAA);
    chk("R3 dac", dac_o, 12'h000);
    @(negedge clk); crc = 0;
    cyc(3);
    settle();
    chk("R9 sticky", sif_o, 16'hCAAA);
    do_reload();
    settle();
    chk("R9 reload clears", stat, 0);

    // R11: ram disabled
    @(negedge clk); ram = 1;
    cyc(3 * Q);
    settle();
    chk("R11 disabled ram", act, 0);
    // R4
    @(negedge clk); en = 4'hF;
    cyc(Q + 1);
    settle();
    chk("R4 code", sif_o, 16'hCF0F);
    chk("R4 dac", dac_o, 12'h000);
    // R8: connection behind ram
    @(negedge clk); bhi = 1;
    cyc(Q + 1);
    settle();
    chk("R8 stat both", stat, 5'b01010);
    chk("R8 ram wins", sif_o, 16'hCF0F);
    @(negedge clk); ram = 0; bhi = 0;
    do_reload();

    // R5
    @(negedge clk); regp = 1;
    cyc(Q + 1); regp = 0;
    settle();
    chk("R5 code", sif_o, 16'hCE38);
    chk("R5 lo", hi, 0);
    do_reload();

    // R6 via lo comparator
    @(negedge clk); blo = 1;
    cyc(Q + 1); blo = 0;
    settle();
    chk("R6 code", sif_o, 16'hCFCF);
    chk("R6 dac", dac_o, 12'hFFF);
    do_reload();

    // R9: reload on the qualifying edge wins
    @(negedge clk); blo = 1;
    cyc(Q - 1); reload = 1;
    @(negedge clk); reload = 0; blo = 0;
    settle();
    chk("R9 reload beats set", stat, 0);

    // R7
    @(negedge clk); cm = 1; cmv = 13'h1ABC;
    cyc(Q + 1); cmv = 13'h0005;
    settle();
    chk("R7 code", sif_o, 16'hFABC);
    chk("R7 hi", hi, 1);
    @(negedge clk); cm = 0;
    do_reload();

    // R8: all at once
    @(negedge clk); crc = 1; ram = 1; regp = 1; blo = 1; cm = 1;
    cyc(Q + 1);
    settle();
    chk("R8 all stat", stat, 5'b11111);
    chk("R8 crc wins", sif_o, 16'hCAAA);
    // R9: async reset clears
    @(negedge clk); crc = 0; ram = 0; regp = 0; blo = 0; cm = 0;
    #3 rst_n = 0;
    #4;
    chk("R9 reset clears", stat, 0);
    @(negedge clk); rst_n = 1;
    cyc(2);
    settle();
    chk("R1 after reset", sif_o, sif_i);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule